// File: doc/BRIEF.md
# Atomic swap and compare-swap memory unit

This block is a single-port, byte-addressed memory that serves one request per cycle. A request carries a command, an address, an access size of 1, 2, 4 or 8 bytes, write data, a compare value and two flags. One flag asks for a response and the other suppresses the request entirely. The supported commands are plain read, plain write, unconditional swap, conditional swap and invalidate. Both swap forms return the value that was in memory before the request. The conditional form replaces that value only when it matches the compare value. Plain writes are committed only while an external write-permit input is high. That input is how an outside reservation tracker vetoes stores.

The array is read and updated in the cycle a request is sampled. Every outcome then travels through a fixed-depth pipeline, so each response appears exactly `LATENCY` cycles after its request, whatever the command. A request that cannot be served raises a one-cycle error pulse and leaves memory untouched. It still gets a response if it asked for one. Such requests include an unknown command, a conditional swap of the wrong size, a misaligned address, or an access that runs past the end of the array.

Top module: `amo_mem_unit`

## Requirements
- R1: Synchronous active-low reset clears every byte of the array to zero and drives `rsp_valid` and `err_pulse` low.
- R2: A read (command code 0) returns the `size` bytes at `addr`, little-endian (lowest address in bits 7:0), zero-extended to 64 bits. Size code s selects 2^s bytes.
- R3: A write (command code 1) stores the low bytes of `req_wdata` only when `wr_permit` is 1. When it is 0, memory keeps its contents. A write's response data is zero.
- R4: A swap (command code 2) always stores the new data and returns the previous memory contents.
- R5: A conditional swap (command code 3) of 4 or 8 bytes returns the previous contents in every case. It stores the new data only when the previous contents equal the compare value. For 4 bytes, only `req_cmp[31:0]` takes part in the comparison.
- R6: A conditional swap with size code 0 or 1 (1 or 2 bytes) is illegal.
- R7: A read, write, swap or conditional swap is illegal when `addr` is not a multiple of its size or when `addr` plus the byte count exceeds `DEPTH`.
- R8: An illegal request does not change memory. Command codes 5, 6 and 7 are also illegal. It pulses `err_pulse` for exactly one cycle in its response slot. It returns a response with zero data if `req_need_rsp` is set.
- R9: A request with `req_inhibit` set does not access the array and produces no response and no error.
- R10: An invalidate (command code 4) never touches the array. It returns a zero-data response only if `req_need_rsp` is set.
- R11: The response and error pulse of a request sampled at clock edge n appear after edge n+`LATENCY`-1, for the whole of the next cycle and for no other cycle. A request with `req_need_rsp` low gives no `rsp_valid`.
- R12: Requests may be issued on consecutive cycles. A request sees the array as updated by the request sampled one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_cmd | input | 3 | Command: 0 read, 1 write, 2 swap, 3 conditional swap, 4 invalidate |
| req_size | input | 2 | Access size code, byte count 2^code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Data for write and swap, low bytes used |
| req_cmp | input | 64 | Compare value for conditional swap |
| req_need_rsp | input | 1 | Request expects a response |
| req_inhibit | input | 1 | Suppress access and response |
| wr_permit | input | 1 | Allows a plain write to commit |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | 64 | Returned data, zero-extended |
| err_pulse | output | 1 | The request in this slot was illegal |

## Verification
The bound checker watches cycle-level properties on every edge. Responses line up with requests delayed by the latency. Inhibited, illegal, permit-blocked and invalidate requests never raise the array write enable. Undersized conditional swaps are always flagged. Only the bench can show data correctness. That covers little-endian extraction, the merge of partial writes into a word, the returned old value of swaps, and the truncated 32-bit compare. It also covers the fact that a refused or failed store left memory intact, which the bench shows by reading the location back. The one-cycle width of the error pulse and read-after-write on back-to-back cycles are likewise bench scenarios.

// File: rtl/amo_pkg.sv
// Shared definitions for the atomic memory unit.
// Assumes command and size codes as listed in the brief.
package amo_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_SWAP  = 3'd2,
        CMD_CSWAP = 3'd3,
        CMD_INVAL = 3'd4
    } amo_cmd_e;

    // One entry of the response pipeline.
    typedef struct packed {
        logic        valid;
        logic        err;
        logic [63:0] data;
    } rsp_slot_t;

    // Byte count for a size code.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Mask of the low bytes covered by a size code.
    function automatic logic [63:0] size_mask(input logic [1:0] code);
        logic [63:0] m;
        case (code)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/amo_decode.sv
// Request legality and address split.
// Decides whether a request touches the array and whether it is illegal
// (unknown command, undersized conditional swap, misaligned, out of range).
// Assumes DEPTH is a multiple of 8 bytes and fits in ADDR_W bits.
module amo_decode #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH / 8)
) (
    input  logic [2:0]        cmd,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic              touches_array,
    output logic              illegal,
    output logic [2:0]        byte_off,
    output logic [IDX_W-1:0]  word_idx
);
    import amo_pkg::*;

    logic              known_cmd;
    logic              short_cswap;
    logic              misaligned;
    logic              out_of_range;
    logic [ADDR_W:0]   end_addr;
    logic [3:0]        nbytes;

    // Classify the command code.
    always_comb begin
        known_cmd     = 1'b1;
        touches_array = 1'b0;
        case (cmd)
            CMD_READ, CMD_WRITE, CMD_SWAP, CMD_CSWAP: touches_array = 1'b1;
            CMD_INVAL:                                touches_array = 1'b0;
            default:                                  known_cmd     = 1'b0;
        endcase
    end

    // Alignment and range checks against the configured depth.
    always_comb begin
        nbytes       = size_bytes(size);
        misaligned   = (addr[2:0] & (nbytes[2:0] - 3'd1)) != 3'd0;
        end_addr     = {1'b0, addr} + {{(ADDR_W - 3){1'b0}}, nbytes};
        out_of_range = end_addr > (ADDR_W + 1)'(DEPTH);
        short_cswap  = (cmd == CMD_CSWAP) && (size < 2'd2);
        illegal      = !known_cmd || short_cswap ||
                       (touches_array && (misaligned || out_of_range));
    end

    // Split the address into word index and byte lane.
    always_comb begin
        byte_off = addr[2:0];
        word_idx = addr[3 +: IDX_W];
    end

endmodule

// File: rtl/amo_lane.sv
// Lane alignment for one 64-bit storage word.
// Extracts the old value at a byte offset, builds the merged word holding
// the new bytes, and compares the old value with the compare operand.
// Assumes the access is naturally aligned inside the word.
module amo_lane (
    input  logic [63:0] old_word,
    input  logic [2:0]  byte_off,
    input  logic [1:0]  size,
    input  logic [63:0] wdata,
    input  logic [63:0] cmp,
    output logic [63:0] old_val,
    output logic [63:0] merged_word,
    output logic        cmp_hit
);
    import amo_pkg::*;

    logic [5:0]  bit_off;
    logic [63:0] field_mask;
    logic [63:0] placed_mask;
    logic [63:0] placed_data;

    // Extract the addressed field, little-endian, zero-extended.
    always_comb begin
        bit_off    = {byte_off, 3'b000};
        field_mask = size_mask(size);
        old_val    = (old_word >> bit_off) & field_mask;
    end

    // Place the new bytes into the word and keep the others.
    always_comb begin
        placed_mask = field_mask << bit_off;
        placed_data = (wdata & field_mask) << bit_off;
        merged_word = (old_word & ~placed_mask) | placed_data;
    end

    // Compare: 32-bit accesses use only the low half of the operand.
    always_comb begin
        if (size == 2'd2) cmp_hit = old_val[31:0] == cmp[31:0];
        else              cmp_hit = old_val == cmp;
    end

endmodule

// File: rtl/amo_array.sv
// Word-organised storage with one combinational read and one write port.
// Assumes a whole-word write; byte merging happens upstream.
// Synchronous active-low reset clears every word.
module amo_array #(
    parameter int WORDS  = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [63:0]      wr_word,
    output logic [63:0]      rd_word
);
    logic [63:0] mem [WORDS];

    // Clear on reset, otherwise store the merged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wr_word;
        end
    end

    // Present the addressed word in the same cycle.
    always_comb rd_word = mem[idx];

endmodule

// File: rtl/amo_rsp_pipe.sv
// Fixed-depth delay line for response slots.
// A slot entered at edge n leaves the last stage after edge n+LATENCY-1.
// Assumes LATENCY >= 1.
module amo_rsp_pipe #(
    parameter int LATENCY = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  amo_pkg::rsp_slot_t  slot_in,
    output amo_pkg::rsp_slot_t  slot_out
);
    import amo_pkg::*;

    rsp_slot_t stage [LATENCY];

    // First stage captures the outcome of the sampled request.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= slot_in;
    end

    // Remaining stages shift the outcome forward one per cycle.
    generate
        for (genvar s = 1; s < LATENCY; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage[s] <= '0;
                else        stage[s] <= stage[s-1];
            end
        end
    endgenerate

    assign slot_out = stage[LATENCY-1];

endmodule

// File: rtl/amo_mem_unit.sv
// Single-port atomic memory: read, write, swap, conditional swap and
// invalidate, one request per cycle, fixed response latency.
// Assumes requests are naturally aligned (misaligned ones are flagged),
// DEPTH is a multiple of 8, and write permission comes from outside.
module amo_mem_unit #(
    parameter int ADDR_W  = 16,
    parameter int DEPTH   = 256,
    parameter int LATENCY = 3,
    localparam int WORDS  = DEPTH / 8,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [63:0]       req_cmp,
    input  logic              req_need_rsp,
    input  logic              req_inhibit,
    input  logic              wr_permit,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    output logic              err_pulse
);
    import amo_pkg::*;

    logic             touches_array;
    logic             dec_illegal;
    logic [2:0]       byte_off;
    logic [IDX_W-1:0] word_idx;
    logic [63:0]      rd_word;
    logic [63:0]      old_val;
    logic [63:0]      merged_word;
    logic             cmp_hit;
    logic             accept;
    logic             serve;
    logic             arr_we;
    logic             returns_old;
    rsp_slot_t        slot_in;
    rsp_slot_t        slot_out;

    amo_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_decode (
        .cmd           (req_cmd),
        .size          (req_size),
        .addr          (req_addr),
        .touches_array (touches_array),
        .illegal       (dec_illegal),
        .byte_off      (byte_off),
        .word_idx      (word_idx)
    );

    amo_array #(.WORDS(WORDS)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .idx     (word_idx),
        .wr_word (merged_word),
        .rd_word (rd_word)
    );

    amo_lane u_lane (
        .old_word    (rd_word),
        .byte_off    (byte_off),
        .size        (req_size),
        .wdata       (req_wdata),
        .cmp         (req_cmp),
        .old_val     (old_val),
        .merged_word (merged_word),
        .cmp_hit     (cmp_hit)
    );

    // Qualify the request: inhibited requests vanish, illegal ones do no access.
    always_comb begin
        accept = req_valid && !req_inhibit;
        serve  = accept && !dec_illegal && touches_array;
    end

    // Select the store condition per command.
    always_comb begin
        arr_we      = 1'b0;
        returns_old = 1'b0;
        if (serve) begin
            case (req_cmd)
                CMD_READ:  returns_old = 1'b1;
                CMD_WRITE: arr_we      = wr_permit;
                CMD_SWAP:  begin arr_we = 1'b1;    returns_old = 1'b1; end
                CMD_CSWAP: begin arr_we = cmp_hit; returns_old = 1'b1; end
                default:   arr_we      = 1'b0;
            endcase
        end
    end

    // Build the outcome that enters the latency pipeline.
    always_comb begin
        slot_in.valid = accept && req_need_rsp;
        slot_in.err   = accept && dec_illegal;
        slot_in.data  = returns_old ? old_val : 64'd0;
    end

    amo_rsp_pipe #(.LATENCY(LATENCY)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_in  (slot_in),
        .slot_out (slot_out)
    );

    // Drive the response ports from the last pipeline stage.
    always_comb begin
        rsp_valid = slot_out.valid;
        err_pulse = slot_out.err;
        rsp_data  = slot_out.data;
    end

endmodule

// File: rtl/amo_mem_chk.sv
// Protocol checker for amo_mem_unit, attached by bind.
// Keeps its own delayed copy of request intent to check response timing.
module amo_mem_chk #(
    parameter int LATENCY = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [2:0] req_cmd,
    input logic [1:0] req_size,
    input logic       req_need_rsp,
    input logic       req_inhibit,
    input logic       wr_permit,
    input logic       arr_we,
    input logic       dec_illegal,
    input logic       rsp_valid,
    input logic       err_pulse
);
    logic [LATENCY-1:0] want_rsp;
    logic [LATENCY-1:0] want_err;

    // Delay line of expected response and error slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_rsp <= '0;
            want_err <= '0;
        end else begin
            want_rsp <= (want_rsp << 1) |
                        LATENCY'(req_valid && !req_inhibit && req_need_rsp);
            want_err <= (want_err << 1) |
                        LATENCY'(req_valid && !req_inhibit && dec_illegal);
        end
    end

    AST_RSP_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == want_rsp[LATENCY-1]) else $error("response slot mismatch"); // R11
    AST_ERR_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse == want_err[LATENCY-1]) else $error("error slot mismatch"); // R8
    AST_INHIBIT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_inhibit) |-> !arr_we) else $error("inhibited store"); // R9
    AST_ILLEGAL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_illegal |-> !arr_we) else $error("illegal store"); // R8
    AST_SHORT_CSWAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd3 && req_size < 2'd2) |-> dec_illegal)
        else $error("short conditional swap accepted"); // R6
    AST_WRITE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd1 && !wr_permit) |-> !arr_we)
        else $error("write without permit"); // R3
    AST_INVAL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd4) |-> !arr_we) else $error("invalidate stored"); // R10
    AST_SWAP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_inhibit && req_cmd == 3'd2 && !dec_illegal) |-> arr_we)
        else $error("swap did not store"); // R4

endmodule

bind amo_mem_unit amo_mem_chk #(.LATENCY(LATENCY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_cmd      (req_cmd),
    .req_size     (req_size),
    .req_need_rsp (req_need_rsp),
    .req_inhibit  (req_inhibit),
    .wr_permit    (wr_permit),
    .arr_we       (arr_we),
    .dec_illegal  (dec_illegal),
    .rsp_valid    (rsp_valid),
    .err_pulse    (err_pulse)
);

// File: tb/tb_amo_mem_unit.sv
// Self-checking bench: a vector table walked in order, then directed tests.
module tb_amo_mem_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DEPTH      = 256;
    localparam int LAT        = 3;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [2:0]  cmd;
        logic [1:0]  size;
        logic [15:0] addr;
        logic [63:0] wdata;
        logic [63:0] cmp;
        logic        need;
        logic        inh;
        logic        perm;
        logic        exp_valid;
        logic        exp_err;
        logic [63:0] exp_data;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        // R3 permitted 8-byte write
        '{3'd1, 2'd3, 16'h0010, 64'h1122334455667788, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'd0},
        // R2 reads of each size, little-endian
        '{3'd0, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h1122334455667788},
        '{3'd0, 2'd0, 16'h0011, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h77},
        '{3'd0, 2'd1, 16'h0012, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h5566},
        '{3'd0, 2'd2, 16'h0014, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h11223344},
        // R3 write without permit, then read back unchanged
        '{3'd1, 2'd2, 16'h0010, 64'hAAAAAAAA, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'd0},
        '{3'd0, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h1122334455667788},
        // R4 swap returns old, stores new
        '{3'd2, 2'd1, 16'h0010, 64'hBEEF, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'h7788},
        '{3'd0, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h112233445566BEEF},
        // R5 4-byte conditional swap, upper compare half ignored, hit
        '{3'd3, 2'd2, 16'h0014, 64'hCAFEF00D, 64'hFFFFFFFF11223344, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'h11223344},
        '{3'd0, 2'd2, 16'h0014, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'hCAFEF00D},
        // R5 8-byte conditional swap, miss: old returned, no store
        '{3'd3, 2'd3, 16'h0010, 64'h1, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'hCAFEF00D5566BEEF},
        '{3'd0, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'hCAFEF00D5566BEEF},
        // R5 8-byte conditional swap, hit
        '{3'd3, 2'd3, 16'h0010, 64'h0123456789ABCDEF, 64'hCAFEF00D5566BEEF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'hCAFEF00D5566BEEF},
        '{3'd0, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0123456789ABCDEF},
        // R6 2-byte conditional swap is illegal; R8 memory unchanged
        '{3'd3, 2'd1, 16'h0010, 64'd0, 64'hCDEF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'd0},
        '{3'd0, 2'd1, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'hCDEF},
        // R7 misaligned read
        '{3'd0, 2'd2, 16'h0012, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'd0},
        // R7 write beyond the end, no wrap into word 0
        '{3'd1, 2'd3, 16'h0100, 64'hDEADDEADDEADDEAD, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'd0},
        '{3'd0, 2'd3, 16'h0000, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'd0},
        // R7 last byte in range is legal
        '{3'd0, 2'd0, 16'h00FF, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'd0},
        // R7 8-byte access straddling the end
        '{3'd0, 2'd3, 16'h00FC, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'd0},
        // R10 invalidate with and without response
        '{3'd4, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'd0},
        '{3'd4, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'd0},
        // R9 inhibited write: silent, memory unchanged
        '{3'd1, 2'd3, 16'h0010, 64'hFFFFFFFFFFFFFFFF, 64'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'd0},
        '{3'd0, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0123456789ABCDEF},
        // R11 swap without response still stores
        '{3'd2, 2'd0, 16'h0020, 64'h5A, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'd0},
        '{3'd0, 2'd0, 16'h0020, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h5A},
        // R8 unknown command code
        '{3'd5, 2'd3, 16'h0010, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'd0},
        // R8 illegal without response request: error pulse only
        '{3'd3, 2'd0, 16'h0020, 64'd0, 64'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 64'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_cmd = '0;
    logic [1:0]        req_size = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [63:0]       req_wdata = '0;
    logic [63:0]       req_cmp = '0;
    logic              req_need_rsp = 1'b0;
    logic              req_inhibit = 1'b0;
    logic              wr_permit = 1'b0;
    logic              rsp_valid;
    logic [63:0]       rsp_data;
    logic              err_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    amo_mem_unit #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LATENCY(LAT)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_cmd      (req_cmd),
        .req_size     (req_size),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_cmp      (req_cmp),
        .req_need_rsp (req_need_rsp),
        .req_inhibit  (req_inhibit),
        .wr_permit    (wr_permit),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .err_pulse    (err_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check_out(input string tag, input logic v, input logic e,
                             input logic [63:0] d);
        checks++;
        if (rsp_valid !== v || err_pulse !== e || (v && rsp_data !== d)) begin
            errors++;
            $display("FAIL %s: actual valid=%0b err=%0b data=%h expected valid=%0b err=%0b data=%h",
                     tag, rsp_valid, err_pulse, rsp_data, v, e, d);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [1:0] s, input logic [15:0] a,
                         input logic [63:0] w, input logic [63:0] k,
                         input logic n, input logic i, input logic p);
        req_valid = 1'b1; req_cmd = c; req_size = s; req_addr = a;
        req_wdata = w; req_cmp = k; req_need_rsp = n; req_inhibit = i; wr_permit = p;
    endtask

    // One isolated request: idle before its slot, expected in its slot, idle after.
    task automatic run_vec(input vec_t t, input string tag);
        @(negedge clk);
        drive(t.cmd, t.size, t.addr, t.wdata, t.cmp, t.need, t.inh, t.perm);
        @(negedge clk);
        req_valid = 1'b0;
        if (LAT > 1) begin
            repeat (LAT - 2) @(negedge clk);
            check_out({tag, " R11 early"}, 1'b0, 1'b0, 64'd0);
            @(negedge clk);
        end
        check_out(tag, t.exp_valid, t.exp_err, t.exp_data);
        @(negedge clk);
        check_out({tag, " R8 one-cycle"}, 1'b0, 1'b0, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs idle during and after reset
        check_out("R1 reset outputs", 1'b0, 1'b0, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 after reset", 1'b0, 1'b0, 64'd0);
        run_vec('{3'd0, 2'd3, 16'h0040, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'd0},
                "R1 cleared array");

        for (int v = 0; v < NV; v++) begin
            run_vec(TBL[v], $sformatf("vector %0d", v));
        end

        // R12 back-to-back write then read of the same word
        @(negedge clk);
        drive(3'd1, 2'd3, 16'h0030, 64'h0F1E2D3C4B5A6978, 64'd0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        drive(3'd0, 2'd3, 16'h0030, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (LAT - 2) @(negedge clk);
        check_out("R12 write slot", 1'b1, 1'b0, 64'd0);
        @(negedge clk);
        check_out("R12 read sees write", 1'b1, 1'b0, 64'h0F1E2D3C4B5A6978);

        // R1 reset mid-run clears stored data
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_vec('{3'd0, 2'd3, 16'h0030, 64'd0, 64'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'd0},
                "R1 reset clears");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule